// File: doc/BRIEF.md
# SPI EEPROM command engine

This block is the serial front end of an EEPROM-style memory. It acts as an SPI slave in clock modes 0 and 3. A fast system clock samples the serial clock, the active-low select and the serial input. The block shifts in a one-byte command, decodes it, and then does one of three things. It streams bytes out of a 512-byte on-chip array, collects bytes for a 32-byte page write, or reads or writes the status byte.

The write-enable state, the status contents and the write-cycle busy flag live in a separate protection and status controller. This engine only sends that controller single-cycle request strobes and reads back its `busy_in`, `wen_in` and `status_in` signals. A page commit request carries the page base, a byte-valid mask and the buffered bytes. The engine copies the buffered bytes into its array only when the controller grants the commit in the cycle the request is high.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset the engine is deselected. While `cs_n` stays low with no falling edge since reset, serial traffic causes no strobe and `so_oe` stays 0.
- R2: A command byte of the form 0000_x110 pulses `req_set_wen` and a byte 0000_x100 pulses `req_clr_wen`, whatever the value of bit 3. At most one request strobe is high in any cycle.
- R3: A command byte that is not one of the six valid codes, including any byte whose upper nibble is nonzero, is ignored. The engine raises no strobe, and `so_oe` stays 0 until the next `cs_n` falling edge. Every `cs_n` rise drops `so_oe` on the next cycle.
- R4: READ is 0000_a011, where a is address bit 8, followed by the low address byte. Data then leaves on `so`, MSB first. A new bit is driven after each falling serial-clock edge. The address increments after each byte and wraps from 0x1FF to 0x000.
- R5: RDSR (0000_x101) shifts out `status_in` MSB first, and repeats it for as long as the select stays low.
- R6: WRSR (0000_x001) followed by one byte pulses `req_wr_status`, with that byte on `status_wdata`, when `cs_n` rises. This happens only if `wen_in` was 1 when the command byte completed.
- R7: WRITE (0000_a010) takes an address byte and then data bytes. Each byte goes to the page slot given by the 5 low address bits, which then increment and wrap inside the page. The commit shows `commit_base` with its 5 low bits at zero, and a mask of the slots that were written.
- R8: `req_commit` is a one-cycle pulse. It is raised only when `cs_n` rises right after a whole number of data bytes, with at least one data byte received. Otherwise the write is dropped.
- R9: WRITE issued while `wen_in` is 0 raises no commit and leaves the array unchanged.
- R10: While `busy_in` is 1, every command other than RDSR is ignored. RDSR still returns `status_in`.
- R11: The array takes the buffered bytes only if `commit_grant` is 1 in the cycle `req_commit` is high. The page buffer is not modified while those bytes are being copied into the array.
- R12: Modes 0 and 3 behave the same. In mode 3 the clock idles high, and a falling edge before the first rising edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| busy_in | input | 1 | Write cycle in progress (from the controller) |
| wen_in | input | 1 | Write-enable latch state (from the controller) |
| status_in | input | 8 | Status byte returned by RDSR |
| commit_grant | input | 1 | Controller allows the pending commit |
| req_set_wen | output | 1 | Request: set the write-enable latch |
| req_clr_wen | output | 1 | Request: clear the write-enable latch |
| req_wr_status | output | 1 | Request: write `status_wdata` to status |
| status_wdata | output | 8 | Byte received by WRSR |
| req_commit | output | 1 | Request: commit the page buffer |
| commit_base | output | AW (9) | Page base address |
| commit_mask | output | 2**PB (32) | Written-slot mask |
| commit_data | output | 8*2**PB (256) | Page buffer bytes, slot 0 in the low byte |

## Verification
The hardest cases to reach are the busy window and the write paths that must stay silent. To reach the busy window, the bench's controller model holds `busy_in` for a long time after each granted commit. RDSR and READ are issued inside that window. Dropped writes are probed in three ways: a select rise a few bits into a byte, a WRITE with the latch clear, and a refused grant. Each case is followed by reading the same address back over the serial port.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADDR, S_RDAT, S_WDAT, S_SRRD, S_SRWR, S_IGN
  } eep_state_t;

  // low three bits of a command byte; upper nibble must be zero
  localparam logic [2:0] OP_SETWE = 3'b110;
  localparam logic [2:0] OP_CLRWE = 3'b100;
  localparam logic [2:0] OP_STRD  = 3'b101;
  localparam logic [2:0] OP_STWR  = 3'b001;
  localparam logic [2:0] OP_RD    = 3'b011;
  localparam logic [2:0] OP_WR    = 3'b010;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] m1, m2;

  always_ff @(posedge clk) begin
    if (rst) begin
      m1 <= '0;
      m2 <= '0;
    end else begin
      m1 <= d;
      m2 <= m1;
    end
  end

  assign q = m2;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_pagebuf.sv
module eep_pagebuf #(
  parameter int AW = 9,
  parameter int PB = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [AW-1:0]         start_addr,
  input  logic                  push,
  input  logic [7:0]            push_data,
  input  logic                  drain_go,
  output logic [AW-1:0]         base,
  output logic [(1<<PB)-1:0]    mask,
  output logic [8*(1<<PB)-1:0]  flat,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_waddr,
  output logic [7:0]            mem_wdata
);
  localparam int PAGE = 1 << PB;
  localparam int HW   = AW - PB;

  logic [7:0]    slots [PAGE];
  logic [HW-1:0] hi;
  logic [PB-1:0] idx, dcnt;
  logic          draining;

  always_ff @(posedge clk) begin
    if (push && !start) slots[idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0; idx <= '0; mask <= '0; dcnt <= '0; draining <= 1'b0;
    end else begin
      if (start) begin
        hi   <= start_addr[AW-1:PB];
        idx  <= start_addr[PB-1:0];
        mask <= '0;
      end else if (push) begin
        mask[idx] <= 1'b1;
        idx       <= idx + 1'b1;
      end
      if (drain_go) begin
        draining <= 1'b1;
        dcnt     <= '0;
      end else if (draining) begin
        dcnt <= dcnt + 1'b1;
        if (dcnt == PB'(PAGE - 1)) draining <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_flat
    assign flat[g*8 +: 8] = slots[g];
  end

  assign base      = {hi, {PB{1'b0}}};
  assign mem_we    = draining & mask[dcnt];
  assign mem_waddr = {hi, dcnt};
  assign mem_wdata = slots[dcnt];

  assert_buf_stable_R11: assert property (@(posedge clk) disable iff (rst)
    draining |-> (!start && !push));
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
  import eep_pkg::*;
#(
  parameter int AW = 9,
  parameter int PB = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck,
  input  logic                  cs_n,
  input  logic                  si,
  output logic                  so,
  output logic                  so_oe,
  input  logic                  busy_in,
  input  logic                  wen_in,
  input  logic [7:0]            status_in,
  input  logic                  commit_grant,
  output logic                  req_set_wen,
  output logic                  req_clr_wen,
  output logic                  req_wr_status,
  output logic [7:0]            status_wdata,
  output logic                  req_commit,
  output logic [AW-1:0]         commit_base,
  output logic [(1<<PB)-1:0]    commit_mask,
  output logic [8*(1<<PB)-1:0]  commit_data
);
  localparam int PAGE = 1 << PB;

  logic [2:0] sync_q;
  logic       sck_s, cs_s, si_s, sck_q, cs_q;
  logic       sck_r, sck_f, cs_rise, cs_fall;

  eep_sync #(.W(3)) u_sync (.clk(clk), .rst(rst), .d({sck, cs_n, si}), .q(sync_q));
  assign {sck_s, cs_s, si_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin sck_q <= 1'b0; cs_q <= 1'b0; end
    else     begin sck_q <= sck_s; cs_q <= cs_s; end
  end
  assign sck_r   = sck_s & ~sck_q;
  assign sck_f   = ~sck_s & sck_q;
  assign cs_rise = cs_s & ~cs_q;
  assign cs_fall = ~cs_s & cs_q;

  eep_state_t    st;
  logic [2:0]    bitcnt, ocnt, op;
  logic [6:0]    shreg;
  logic [7:0]    rx_byte, out_sh, mem_rdata;
  logic          a8, got, byte_done, op_ok;
  logic [AW-1:0] rd_addr;

  assign rx_byte   = {shreg, si_s};
  assign byte_done = sck_r && (bitcnt == 3'd7) && !cs_fall && !cs_rise && (st != S_IDLE);
  assign op_ok     = (rx_byte[7:4] == 4'd0) &&
                     (rx_byte[2:0] inside {OP_SETWE, OP_CLRWE, OP_STRD, OP_STWR, OP_RD, OP_WR});

  logic          pb_start, pb_push, pb_we;
  logic [AW-1:0] pb_waddr;
  logic [7:0]    pb_wdata;

  assign pb_start = byte_done && (st == S_ADDR) && (op == OP_WR);
  assign pb_push  = byte_done && (st == S_WDAT);

  eep_pagebuf #(.AW(AW), .PB(PB)) u_page (
    .clk(clk), .rst(rst), .start(pb_start), .start_addr(AW'({a8, rx_byte})),
    .push(pb_push), .push_data(rx_byte), .drain_go(req_commit && commit_grant),
    .base(commit_base), .mask(commit_mask), .flat(commit_data),
    .mem_we(pb_we), .mem_waddr(pb_waddr), .mem_wdata(pb_wdata));

  eep_mem #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .we(pb_we), .waddr(pb_waddr), .wdata(pb_wdata),
    .raddr(rd_addr), .rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; bitcnt <= '0; ocnt <= '0; op <= '0; shreg <= '0;
      out_sh <= '0; a8 <= 1'b0; got <= 1'b0; rd_addr <= '0; so_oe <= 1'b0;
      req_set_wen <= 1'b0; req_clr_wen <= 1'b0; req_wr_status <= 1'b0;
      req_commit <= 1'b0; status_wdata <= '0;
    end else begin
      req_set_wen <= 1'b0; req_clr_wen <= 1'b0;
      req_wr_status <= 1'b0; req_commit <= 1'b0;
      if (cs_fall) begin
        st <= S_OPC; bitcnt <= '0; ocnt <= '0; got <= 1'b0; so_oe <= 1'b0;
      end else if (cs_rise) begin
        st <= S_IDLE; so_oe <= 1'b0;
        if (bitcnt == 3'd0 && got) begin
          if (st == S_WDAT) req_commit    <= 1'b1;
          if (st == S_SRWR) req_wr_status <= 1'b1;
        end
      end else if (st != S_IDLE) begin
        if (sck_r) begin
          shreg  <= rx_byte[6:0];
          bitcnt <= bitcnt + 1'b1;
        end
        if (byte_done) begin
          case (st)
            S_OPC: begin
              a8 <= rx_byte[3];
              op <= rx_byte[2:0];
              if (!op_ok || (busy_in && rx_byte[2:0] != OP_STRD)) st <= S_IGN;
              else begin
                case (rx_byte[2:0])
                  OP_SETWE: begin req_set_wen <= 1'b1; st <= S_IGN; end
                  OP_CLRWE: begin req_clr_wen <= 1'b1; st <= S_IGN; end
                  OP_STRD:  st <= S_SRRD;
                  OP_STWR:  st <= wen_in ? S_SRWR : S_IGN;
                  OP_RD:    st <= S_ADDR;
                  default:  st <= wen_in ? S_ADDR : S_IGN;
                endcase
              end
            end
            S_ADDR: begin
              if (op == OP_RD) begin
                rd_addr <= AW'({a8, rx_byte});
                st      <= S_RDAT;
              end else st <= S_WDAT;
            end
            S_WDAT: got <= 1'b1;
            S_SRWR: begin status_wdata <= rx_byte; got <= 1'b1; end
            default: ;
          endcase
        end
        if (sck_f && (st == S_RDAT || st == S_SRRD)) begin
          so_oe <= 1'b1;
          ocnt  <= ocnt + 1'b1;
          if (ocnt == 3'd0) begin
            out_sh <= (st == S_SRRD) ? status_in : mem_rdata;
            if (st == S_RDAT) rd_addr <= rd_addr + 1'b1;
          end else out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end

  assign so = out_sh[7];

  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_set_wen, req_clr_wen, req_wr_status, req_commit}));
  assert_oe_drop_R3: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !so_oe);
  assert_commit_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    req_commit |=> !req_commit);
  assert_commit_after_rise_R8: assert property (@(posedge clk) disable iff (rst)
    req_commit |-> $past(cs_rise));
  assert_commit_mask_R7: assert property (@(posedge clk) disable iff (rst)
    req_commit |-> (commit_mask != '0));
  assert_busy_block_R10: assert property (@(posedge clk) disable iff (rst)
    (st == S_OPC && byte_done && busy_in) |=> (st == S_IGN || st == S_SRRD));
endmodule

// File: tb/sim_spi_eeprom_engine.sv
module sim_spi_eeprom_engine;
  localparam int H    = 10;
  localparam int BUSY = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0;
  logic so, so_oe, req_set_wen, req_clr_wen, req_wr_status, req_commit;
  logic [7:0]   status_wdata, status_in;
  logic [8:0]   commit_base;
  logic [31:0]  commit_mask;
  logic [255:0] commit_data;
  logic         mode3 = 1'b0, grant_en = 1'b1, done = 1'b0;

  // controller model
  logic       wen = 1'b0;
  logic [7:0] sr = '0;
  int         busy_cnt = 0;
  wire        busy_in = (busy_cnt != 0);
  assign status_in = busy_in ? 8'hFF : {sr[7], 3'b000, sr[3:2], wen, 1'b0};

  always #5 clk = ~clk;

  spi_eeprom_engine u0 (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .busy_in(busy_in), .wen_in(wen), .status_in(status_in), .commit_grant(grant_en),
    .req_set_wen(req_set_wen), .req_clr_wen(req_clr_wen), .req_wr_status(req_wr_status),
    .status_wdata(status_wdata), .req_commit(req_commit), .commit_base(commit_base),
    .commit_mask(commit_mask), .commit_data(commit_data));

  always @(posedge clk) begin
    if (rst) begin
      wen <= 1'b0; sr <= '0; busy_cnt <= 0;
    end else begin
      if (req_set_wen) wen <= 1'b1;
      if (req_clr_wen) wen <= 1'b0;
      if (req_wr_status) begin sr <= status_wdata; wen <= 1'b0; end
      if (req_commit) wen <= 1'b0;
      if (req_wr_status || (req_commit && grant_en)) busy_cnt <= BUSY;
      else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end
  end

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kinds: 1 set-wen, 2 clear-wen, 3 status write (value = byte), 4 commit (value = base)
  task automatic expect_ev(input logic [3:0] k, input logic [11:0] v, input string tag);
    exp_q.push_back({k, v});
    tag_q.push_back(tag);
  endtask

  // monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    logic [15:0] got, e;
    string t;
    if (!rst && (req_set_wen || req_clr_wen || req_wr_status || req_commit)) begin
      got = req_set_wen ? 16'h1000 : req_clr_wen ? 16'h2000 :
            req_wr_status ? {4'd3, 4'd0, status_wdata} : {4'd4, 3'd0, commit_base};
      if (exp_q.size() == 0) chk(1'b0, "unexpected strobe", 32'(got), 32'h0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, 32'(got), 32'(e));
      end
    end
  end

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx, output bit oe_all, output bit oe_any);
    rx = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 8 - nb; i--) begin
      sck = 1'b0; si = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = so; oe_all &= so_oe; oe_any |= so_oe;
      sck = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic sel;
    sck = mode3; repeat (H) @(negedge clk);
    cs_n = 1'b0; repeat (H) @(negedge clk);
  endtask

  task automatic desel;
    if (!mode3) begin sck = 1'b0; repeat (H) @(negedge clk); end
    cs_n = 1'b1; repeat (3*H) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r; bit a, n;
    xfer(b, 8, r, a, n);
  endtask

  task automatic write_cmd(input logic [7:0] opc, input logic [7:0] adr, input logic [7:0] d[$]);
    sel; send(opc); send(adr);
    foreach (d[k]) send(d[k]);
    desel;
  endtask

  task automatic read_chk(input logic [7:0] opc, input logic [7:0] adr, input logic [7:0] e[$], input string tag);
    logic [7:0] r; bit a, n;
    sel; send(opc); send(adr);
    foreach (e[k]) begin
      xfer(8'h00, 8, r, a, n);
      chk(r == e[k] && a, tag, {23'd0, a, r}, {24'd1, e[k]});
    end
    desel;
  endtask

  task automatic wait_idle;
    while (busy_in) @(negedge clk);
    repeat (H) @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(negedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r; bit a, n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1: select held low through reset, no falling edge seen
    chk(so_oe == 1'b0, "R1 so_oe after reset", 32'(so_oe), 32'd0);
    xfer(8'h06, 8, r, a, n);
    xfer(8'h00, 8, r, a, n);
    chk(n == 1'b0 && wen == 1'b0, "R1 no action before first select fall", {n, wen}, 32'd0);
    cs_n = 1'b1; repeat (3*H) @(negedge clk);

    // R2: set write enable, then R7/R11 write four bytes
    expect_ev(4'd1, 12'd0, "R2 set-wen strobe");
    sel; send(8'h06); desel;
    expect_ev(4'd4, 12'h000, "R7 commit base page 0");
    write_cmd(8'h02, 8'h10, '{8'hA0, 8'hA1, 8'hA2, 8'hA3});

    // R10 / R5: busy window
    sel; send(8'h05); xfer(8'h00, 8, r, a, n);
    chk(r == 8'hFF && a, "R10 RDSR while busy", 32'(r), 32'hFF);
    xfer(8'h00, 8, r, a, n);
    chk(r == 8'hFF, "R5 status repeats", 32'(r), 32'hFF);
    desel;
    sel; send(8'h03); send(8'h10); xfer(8'h00, 8, r, a, n); desel;
    chk(n == 1'b0, "R10 READ ignored while busy", 32'(n), 32'd0);
    wait_idle;

    read_chk(8'h03, 8'h10, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, "R4 sequential read");

    // R7: in-page wrap with A8 set (bit 3 of command)
    expect_ev(4'd1, 12'd0, "R2 set-wen bit3 ignored");
    sel; send(8'h0E); desel;
    expect_ev(4'd4, 12'h1E0, "R7 commit base upper page");
    write_cmd(8'h0A, 8'hFE, '{8'hB0, 8'hB1, 8'hB2, 8'hB3});
    wait_idle;
    read_chk(8'h0B, 8'hE0, '{8'hB2, 8'hB3}, "R7 wrapped bytes in page");

    // R4: read wrap 0x1FF -> 0x000
    expect_ev(4'd1, 12'd0, "R2 set-wen");
    sel; send(8'h06); desel;
    expect_ev(4'd4, 12'h000, "R7 commit page 0");
    write_cmd(8'h02, 8'h00, '{8'hC0, 8'hC1});
    wait_idle;
    read_chk(8'h0B, 8'hFE, '{8'hB0, 8'hB1, 8'hC0, 8'hC1}, "R4 address wrap");

    // R8: partial byte before select rise drops the write
    expect_ev(4'd1, 12'd0, "R2 set-wen");
    sel; send(8'h06); desel;
    sel; send(8'h02); send(8'h10); send(8'h55); xfer(8'h55, 3, r, a, n); desel;
    read_chk(8'h03, 8'h10, '{8'hA0}, "R8 partial write dropped");
    // R2: clear write enable
    expect_ev(4'd2, 12'd0, "R2 clear-wen strobe");
    sel; send(8'h04); desel;
    chk(wen == 1'b0, "R2 latch cleared", 32'(wen), 32'd0);

    // R9: write with latch clear
    write_cmd(8'h02, 8'h10, '{8'h77});
    read_chk(8'h03, 8'h10, '{8'hA0}, "R9 write without enable");

    // R11: commit refused
    expect_ev(4'd1, 12'd0, "R2 set-wen");
    sel; send(8'h06); desel;
    grant_en = 1'b0;
    expect_ev(4'd4, 12'h000, "R11 commit request");
    write_cmd(8'h02, 8'h10, '{8'h99});
    grant_en = 1'b1;
    read_chk(8'h03, 8'h10, '{8'hA0}, "R11 refused commit leaves array");

    // R6: status write, first without enable
    write_cmd(8'h01, 8'h8C, '{});
    expect_ev(4'd1, 12'd0, "R2 set-wen");
    sel; send(8'h06); desel;
    expect_ev(4'd3, 12'h08C, "R6 status write strobe");
    sel; send(8'h01); send(8'h8C); desel;
    wait_idle;
    sel; send(8'h05); xfer(8'h00, 8, r, a, n); desel;
    chk(r == 8'h8C, "R5 status read", 32'(r), 32'h8C);

    // R3: invalid command bytes
    sel; send(8'h07); xfer(8'h00, 8, r, a, n); desel;
    chk(n == 1'b0, "R3 invalid low code", 32'(n), 32'd0);
    sel; send(8'h13); xfer(8'h00, 8, r, a, n); desel;
    chk(n == 1'b0, "R3 nonzero upper nibble", 32'(n), 32'd0);

    // R12: mode 3
    mode3 = 1'b1;
    read_chk(8'h03, 8'h10, '{8'hA0, 8'hA1}, "R12 mode 3 read");
    expect_ev(4'd2, 12'd0, "R12 mode 3 clear-wen");
    sel; send(8'h04); desel;

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "expected strobes all seen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule